// File: doc/BRIEF.md
# Synchronous Burst ROM Read Controller

This block sits between an internal read port and an external ROM that delivers data in clock-synchronous bursts. Each accepted read request starts one complete burst on the external bus. The burst always covers the 16-byte line that holds the requested address. On a 16-bit data bus this line takes eight beats, and on a 32-bit data bus it takes four. The beats the requester asked for are packed into a right-aligned result. The remaining beats are still clocked out as dummy reads, and their data is discarded.

The external cycle starts with one address cycle. A programmable number of first-access wait cycles follows, and it can be stretched further by an external wait input. Next come the data cycles, one per beat. A separate, smaller programmable wait count is inserted between consecutive data cycles. The bus-start strobe marks only the address cycle. The external wait input is looked at only before the first beat.

Top module: `brom_burst_rd`

## Requirements
- R1: After a synchronous reset, `rom_cs_n`, `rom_rd_n` and `rom_bs_n` are high, and `busy` and `rsp_valid` are low.
- R2: A request is taken only in a cycle where `req_valid` is high and `busy` is low. A `req_valid` raised while `busy` is high is ignored: it starts no later burst and produces no response.
- R3: The burst opens with one address cycle, followed by N first-access wait cycles, where N is `cfg_first_wait` (0 to 15) sampled when the request is taken.
- R4: If `rom_wait` is high at the end of the last first-access cycle (the address cycle when N is 0), one more wait cycle is added, and this repeats cycle by cycle. A high `rom_wait` at any later point of the burst has no effect on timing.
- R5: Between two consecutive data cycles, B wait cycles are inserted, where B is `cfg_beat_wait` (0 to 3) sampled when the request is taken.
- R6: `rom_bs_n` is low for exactly one cycle per burst, the address cycle.
- R7: Every burst has 8 data cycles when BUS_W is 16 and 4 when BUS_W is 32, whatever the request size. `busy` is high for 1 + N + E + L + (L-1)*B cycles, where E is the number of cycles added by R4 and L is the burst length.
- R8: `rom_cs_n` and `rom_rd_n` are low in exactly the cycles in which `busy` is high.
- R9: `rom_addr` equals `req_addr` with its low four bits cleared during the address cycle. It advances by BUS_W/8 after each data cycle, so it holds `line + 16 - BUS_W/8` in the final data cycle.
- R10: `req_size` is coded 0 = byte, 1 = 16-bit, 2 = 32-bit, with naturally aligned addresses. `rsp_data` holds the requested bytes little-endian, so bit lane 8j..8j+7 carries the byte at `req_addr + j`. The unused upper bits are zero. On the bus, byte lane b of `rom_data` carries the byte at `rom_addr + b`.
- R11: `rsp_valid` is a one-cycle pulse with exactly one per burst. It rises in the cycle after the data cycle that carries the last requested beat, which is no later than the first cycle after the burst.

Ports use the default parameters ADDR_W = 24 and BUS_W = 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_first_wait | input | 4 | Wait cycles before the first beat |
| cfg_beat_wait | input | 2 | Wait cycles before each later beat |
| req_valid | input | 1 | Read request |
| req_addr | input | ADDR_W | Byte address of the read |
| req_size | input | 2 | 0 byte, 1 16-bit, 2 32-bit |
| busy | output | 1 | Burst in progress |
| rsp_valid | output | 1 | Result pulse |
| rsp_data | output | 32 | Assembled, zero-extended result |
| rom_cs_n | output | 1 | ROM chip select, active low |
| rom_rd_n | output | 1 | ROM read strobe, active low |
| rom_bs_n | output | 1 | Bus-start strobe, active low |
| rom_addr | output | ADDR_W | Beat byte address |
| rom_data | input | BUS_W | ROM read data |
| rom_wait | input | 1 | External wait, active high |

## Verification
Two functions can meet in one cycle: the response pulse for the last requested beat, and the end of the burst. When the request covers the final beat of the line, the pulse lands in the same cycle that chip select is released. Vectors aimed at the top bytes of a line provoke this, and the bench judges it by comparing the pulse cycle against the busy length. A second collision puts a fresh `req_valid` and `rom_wait` noise in the middle of a running burst. The bench then requires unchanged beat timing, a single pulse, and an idle bus afterwards.

// File: rtl/brom_pkg.sv
package brom_pkg;

    localparam int RSP_W      = 32;
    localparam int LINE_BYTES = 16;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } xfer_size_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR,
        PH_WAIT1,
        PH_DATA,
        PH_WAITB
    } phase_e;

    typedef struct packed {
        logic [3:0] first;
        logic [3:0] last;
        logic [1:0] lane;
        logic [1:0] size;
    } beat_plan_t;

    function automatic int burst_len(input int bus_w);
        return (bus_w == 32) ? 4 : 8;
    endfunction

    // Which beats of the line hold the requested bytes, and where they sit.
    function automatic beat_plan_t plan_request(input logic [3:0] lo,
                                                input logic [1:0] size,
                                                input int bb);
        beat_plan_t p;
        logic [1:0] sz;
        int nbytes;
        int cnt;
        int fb;
        sz     = (size == 2'd3) ? 2'd2 : size;
        nbytes = 1 << sz;
        fb     = int'(lo) / bb;
        cnt    = (nbytes <= bb) ? 1 : nbytes / bb;
        p.first = 4'(fb);
        p.last  = 4'(fb + cnt - 1);
        p.lane  = 2'(int'(lo) % bb);
        p.size  = sz;
        return p;
    endfunction

endpackage

// File: rtl/brom_seq.sv
module brom_seq
    import brom_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int BUS_W  = 16,
    localparam int BB     = BUS_W / 8,
    localparam int LEN    = burst_len(BUS_W),
    localparam int BEAT_W = $clog2(LEN)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-5:0] req_line,
    input  logic [3:0]        cfg_first_wait,
    input  logic [1:0]        cfg_beat_wait,
    input  logic              rom_wait,
    output logic              accept,
    output logic              beat_fire,
    output logic [BEAT_W-1:0] beat_idx,
    output logic              busy,
    output logic              cs_n,
    output logic              rd_n,
    output logic              bs_n,
    output logic [ADDR_W-1:0] rom_addr
);

    phase_e              state;
    logic [3:0]          wcnt;
    logic [1:0]          bwait_q;
    logic [BEAT_W-1:0]   beat;
    logic [ADDR_W-1:0]   addr_q;
    logic                last_beat;

    assign accept    = (state == PH_IDLE) && req_valid;
    assign last_beat = (beat == BEAT_W'(LEN - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= PH_IDLE;
            wcnt    <= '0;
            bwait_q <= '0;
            beat    <= '0;
            addr_q  <= '0;
        end else begin
            unique case (state)
                PH_IDLE: begin
                    if (req_valid) begin
                        state   <= PH_ADDR;
                        addr_q  <= {req_line, 4'b0000};
                        wcnt    <= cfg_first_wait;
                        bwait_q <= cfg_beat_wait;
                        beat    <= '0;
                    end
                end
                PH_ADDR: begin
                    if (wcnt != 4'd0) begin
                        state <= PH_WAIT1;
                        wcnt  <= wcnt - 4'd1;
                    end else if (rom_wait) begin
                        state <= PH_WAIT1;
                    end else begin
                        state <= PH_DATA;
                    end
                end
                PH_WAIT1: begin
                    if (wcnt != 4'd0) begin
                        wcnt <= wcnt - 4'd1;
                    end else if (!rom_wait) begin
                        state <= PH_DATA;
                    end
                end
                PH_DATA: begin
                    if (last_beat) begin
                        state <= PH_IDLE;
                    end else begin
                        beat   <= beat + BEAT_W'(1);
                        addr_q <= addr_q + ADDR_W'(BB);
                        if (bwait_q != 2'd0) begin
                            state <= PH_WAITB;
                            wcnt  <= {2'b00, bwait_q} - 4'd1;
                        end
                    end
                end
                PH_WAITB: begin
                    if (wcnt == 4'd0) begin
                        state <= PH_DATA;
                    end else begin
                        wcnt <= wcnt - 4'd1;
                    end
                end
                default: state <= PH_IDLE;
            endcase
        end
    end

    assign busy      = (state != PH_IDLE);
    assign cs_n      = !busy;
    assign rd_n      = !busy;
    assign bs_n      = (state != PH_ADDR);
    assign beat_fire = (state == PH_DATA);
    assign beat_idx  = beat;
    assign rom_addr  = addr_q;

    assert_bs_single_R6: assert property (@(posedge clk) disable iff (rst)
        !bs_n |=> bs_n);

    assert_bs_opens_R6: assert property (@(posedge clk) disable iff (rst)
        !bs_n |-> $past(state == PH_IDLE));

    assert_take_idle_R2: assert property (@(posedge clk) disable iff (rst)
        (state == PH_IDLE && req_valid) |=> !bs_n);

    assert_busy_no_restart_R2: assert property (@(posedge clk) disable iff (rst)
        (busy && req_valid && !(state == PH_DATA && last_beat)) |=> bs_n);

    assert_later_wait_ignored_R4: assert property (@(posedge clk) disable iff (rst)
        (state == PH_WAITB && wcnt == 4'd0) |=> beat_fire);

    assert_addr_step_R9: assert property (@(posedge clk) disable iff (rst)
        (beat_fire && !last_beat) |=> rom_addr == $past(rom_addr) + ADDR_W'(BB));

    assert_line_end_R7: assert property (@(posedge clk) disable iff (rst)
        (beat_fire && last_beat) |=> !busy);

endmodule

// File: rtl/brom_pack.sv
module brom_pack
    import brom_pkg::*;
#(
    parameter int BUS_W = 16,
    localparam int BB     = BUS_W / 8,
    localparam int LEN    = burst_len(BUS_W),
    localparam int BEAT_W = $clog2(LEN),
    localparam int SLOTS  = RSP_W / BUS_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [3:0]        req_lo,
    input  logic [1:0]        req_size,
    input  logic              beat_fire,
    input  logic [BEAT_W-1:0] beat_idx,
    input  logic [BUS_W-1:0]  beat_data,
    output logic              rsp_valid,
    output logic [RSP_W-1:0]  rsp_data
);

    beat_plan_t        plan_q;
    logic [RSP_W-1:0]  acc;
    logic [RSP_W-1:0]  merged;
    logic [RSP_W-1:0]  shifted;
    logic [RSP_W-1:0]  masked;
    logic [3:0]        idx4;
    logic [3:0]        slot;
    logic              wanted;
    logic              done;

    assign idx4   = 4'(beat_idx);
    assign slot   = idx4 - plan_q.first;
    assign wanted = beat_fire && (idx4 >= plan_q.first) && (idx4 <= plan_q.last);
    assign done   = wanted && (idx4 == plan_q.last);

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        assign merged[s*BUS_W +: BUS_W] =
            (wanted && slot == 4'(s)) ? beat_data : acc[s*BUS_W +: BUS_W];
    end

    assign shifted = merged >> {plan_q.lane, 3'b000};

    always_comb begin
        unique case (plan_q.size)
            SZ_BYTE: masked = shifted & 32'h0000_00FF;
            SZ_HALF: masked = shifted & 32'h0000_FFFF;
            default: masked = shifted;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            plan_q    <= '0;
            acc       <= '0;
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= done;
            if (start) begin
                plan_q <= plan_request(req_lo, req_size, BB);
                acc    <= '0;
            end else if (wanted) begin
                acc <= merged;
            end
            if (done) begin
                rsp_data <= masked;
            end
        end
    end

    assert_rsp_pulse_R11: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);

    assert_rsp_after_beat_R11: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $past(beat_fire));

    assert_upper_zero_R10: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && plan_q.size == SZ_BYTE) |-> rsp_data[31:8] == 24'd0);

endmodule

// File: rtl/brom_burst_rd.sv
module brom_burst_rd
    import brom_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int BUS_W  = 16,
    localparam int BEAT_W = $clog2(burst_len(BUS_W))
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [3:0]        cfg_first_wait,
    input  logic [1:0]        cfg_beat_wait,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    output logic              busy,
    output logic              rsp_valid,
    output logic [31:0]       rsp_data,
    output logic              rom_cs_n,
    output logic              rom_rd_n,
    output logic              rom_bs_n,
    output logic [ADDR_W-1:0] rom_addr,
    input  logic [BUS_W-1:0]  rom_data,
    input  logic              rom_wait
);

    logic              accept;
    logic              beat_fire;
    logic [BEAT_W-1:0] beat_idx;

    brom_seq #(.ADDR_W(ADDR_W), .BUS_W(BUS_W)) seq_i (
        .clk            (clk),
        .rst            (rst),
        .req_valid      (req_valid),
        .req_line       (req_addr[ADDR_W-1:4]),
        .cfg_first_wait (cfg_first_wait),
        .cfg_beat_wait  (cfg_beat_wait),
        .rom_wait       (rom_wait),
        .accept         (accept),
        .beat_fire      (beat_fire),
        .beat_idx       (beat_idx),
        .busy           (busy),
        .cs_n           (rom_cs_n),
        .rd_n           (rom_rd_n),
        .bs_n           (rom_bs_n),
        .rom_addr       (rom_addr)
    );

    brom_pack #(.BUS_W(BUS_W)) pack_i (
        .clk       (clk),
        .rst       (rst),
        .start     (accept),
        .req_lo    (req_addr[3:0]),
        .req_size  (req_size),
        .beat_fire (beat_fire),
        .beat_idx  (beat_idx),
        .beat_data (rom_data),
        .rsp_valid (rsp_valid),
        .rsp_data  (rsp_data)
    );

    assert_rsp_in_burst_R11: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $past(busy));

    assert_strobes_with_busy_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> !rom_bs_n);

endmodule

// File: tb/brom_burst_rd_tb_top.sv
`timescale 1ns/1ps
module brom_burst_rd_tb_top;

    localparam int ADDR_W = 24;
    localparam int BUS_W  = 16;
    localparam int BB     = BUS_W / 8;
    localparam int LEN    = (BUS_W == 32) ? 4 : 8;
    localparam int NVEC   = 8;

    typedef struct packed {
        logic [23:0] addr;
        logic [1:0]  size;
        logic [3:0]  nw;
        logic [1:0]  bw;
        logic [3:0]  ext;
        logic        noise;
        logic        midreq;
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        '{24'h000100, 2'd2, 4'd2,  2'd1, 4'd0, 1'b0, 1'b0},
        '{24'h00010A, 2'd1, 4'd0,  2'd0, 4'd0, 1'b0, 1'b0},
        '{24'h00020F, 2'd0, 4'd3,  2'd2, 4'd0, 1'b0, 1'b1},
        '{24'h00030C, 2'd2, 4'd0,  2'd3, 4'd2, 1'b1, 1'b0},
        '{24'h000404, 2'd2, 4'd15, 2'd0, 4'd1, 1'b0, 1'b0},
        '{24'h000501, 2'd0, 4'd1,  2'd1, 4'd3, 1'b1, 1'b1},
        '{24'h0006A6, 2'd1, 4'd5,  2'd3, 4'd0, 1'b1, 1'b0},
        '{24'hFFFFF8, 2'd2, 4'd0,  2'd0, 4'd0, 1'b0, 1'b0}
    };

    logic              clk = 1'b0;
    logic              rst;
    logic [3:0]        cfg_first_wait;
    logic [1:0]        cfg_beat_wait;
    logic              req_valid;
    logic [ADDR_W-1:0] req_addr;
    logic [1:0]        req_size;
    logic              busy;
    logic              rsp_valid;
    logic [31:0]       rsp_data;
    logic              rom_cs_n;
    logic              rom_rd_n;
    logic              rom_bs_n;
    logic [ADDR_W-1:0] rom_addr;
    logic [BUS_W-1:0]  rom_data;
    logic              rom_wait;

    int n_chk  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    function automatic logic [7:0] mem_byte(input logic [ADDR_W-1:0] a);
        return 8'(a[7:0] * 8'd7 + 8'd3);
    endfunction

    function automatic logic [BUS_W-1:0] rom_beat(input logic [ADDR_W-1:0] a);
        logic [BUS_W-1:0] r;
        r = '0;
        for (int b = 0; b < BB; b++) r[8*b +: 8] = mem_byte(a + ADDR_W'(b));
        return r;
    endfunction

    assign rom_data = rom_beat(rom_addr);

    brom_burst_rd #(.ADDR_W(ADDR_W), .BUS_W(BUS_W)) dut_i (
        .clk            (clk),
        .rst            (rst),
        .cfg_first_wait (cfg_first_wait),
        .cfg_beat_wait  (cfg_beat_wait),
        .req_valid      (req_valid),
        .req_addr       (req_addr),
        .req_size       (req_size),
        .busy           (busy),
        .rsp_valid      (rsp_valid),
        .rsp_data       (rsp_data),
        .rom_cs_n       (rom_cs_n),
        .rom_rd_n       (rom_rd_n),
        .rom_bs_n       (rom_bs_n),
        .rom_addr       (rom_addr),
        .rom_data       (rom_data),
        .rom_wait       (rom_wait)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    endtask

    task automatic run_vec(input vec_t v);
        int k, busy_n, bs_n_cnt, strobe_bad, rsp_k, rsp_cnt, idle_bad;
        int nbytes, lo, last_need, t_first, exp_busy, exp_rsp_k;
        logic [31:0] got, exp;
        logic [ADDR_W-1:0] first_a, last_a, line;

        nbytes    = 1 << v.size;
        lo        = int'(v.addr[3:0]);
        last_need = (lo + nbytes - 1) / BB;
        t_first   = 1 + int'(v.nw) + int'(v.ext);
        exp_busy  = t_first + LEN + (LEN - 1) * int'(v.bw);
        exp_rsp_k = t_first + last_need * (1 + int'(v.bw)) + 1;
        line      = {v.addr[23:4], 4'h0};
        exp       = '0;
        for (int j = 0; j < nbytes; j++)
            exp = exp | (32'(mem_byte(v.addr + ADDR_W'(j))) << (8 * j));

        @(negedge clk);
        cfg_first_wait = v.nw;
        cfg_beat_wait  = v.bw;
        req_addr       = v.addr;
        req_size       = v.size;
        req_valid      = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;

        k = 0; busy_n = 0; bs_n_cnt = 0; strobe_bad = 0; rsp_k = -1; rsp_cnt = 0;
        got = '0; first_a = '0; last_a = '0;
        while (k < 400) begin
            rom_wait  = (k < int'(v.nw) + int'(v.ext)) ||
                        (v.noise && k >= int'(v.nw) + int'(v.ext) + 1);
            req_valid = v.midreq && (k == 3);
            if (v.midreq && k == 3) req_addr = 24'h00ABC0;
            if (busy) busy_n++;
            if (!rom_bs_n) bs_n_cnt++;
            if (rom_cs_n == busy || rom_rd_n == busy) strobe_bad++;
            if (k == 0) first_a = rom_addr;
            if (busy) last_a = rom_addr;
            if (rsp_valid) begin rsp_cnt++; rsp_k = k; got = rsp_data; end
            if (!busy) break;
            @(negedge clk);
            k++;
        end
        rom_wait  = 1'b0;
        req_valid = 1'b0;
        idle_bad  = 0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            if (busy || rsp_valid || !rom_cs_n) idle_bad++;
        end

        chk("R10 result data", got, exp);
        chk("R11 pulse cycle", 32'(rsp_k), 32'(exp_rsp_k));
        chk("R11 one pulse", 32'(rsp_cnt), 32'd1);
        chk("R7 R3 R4 R5 busy length", 32'(busy_n), 32'(exp_busy));
        chk("R6 bus-start count", 32'(bs_n_cnt), 32'd1);
        chk("R8 strobes follow busy", 32'(strobe_bad), 32'd0);
        chk("R9 first beat address", 32'(first_a), 32'(line));
        chk("R9 last beat address", 32'(last_a), 32'(line + ADDR_W'(16 - BB)));
        chk("R2 no restart after burst", 32'(idle_bad), 32'd0);
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        summary();
        $finish;
    end

    initial begin
        rst = 1'b1;
        req_valid = 1'b0; req_addr = '0; req_size = '0;
        cfg_first_wait = '0; cfg_beat_wait = '0; rom_wait = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 reset cs_n", 32'(rom_cs_n), 32'd1);
        chk("R1 reset rd_n", 32'(rom_rd_n), 32'd1);
        chk("R1 reset bs_n", 32'(rom_bs_n), 32'd1);
        chk("R1 reset busy", 32'(busy), 32'd0);
        chk("R1 reset rsp_valid", 32'(rsp_valid), 32'd0);

        for (int v = 0; v < NVEC; v++) run_vec(VECS[v]);

        // R4: wait held through the whole burst with no first-access stretch window
        run_vec('{24'h000708, 2'd2, 4'd0, 2'd2, 4'd0, 1'b1, 1'b1});

        summary();
        $finish;
    end

endmodule